// File: doc/BRIEF.md
# AES Round-Key Assist Unit

This unit performs the word-level helper step of the AES key schedule. A 128-bit source block and an 8-bit round constant arrive together under a single valid strobe. One clock later the unit presents a 128-bit result. Two of its 32-bit words are S-box substituted copies of source words. The other two are rotated copies of the same words with the constant folded in. A sequencer or software combines these words with the previous round key, using XOR chaining, to produce the next round key.

Only the odd source words (1 and 3) take part in the operation. Each odd word is sent bytewise through the forward AES S-box. The plain substituted word goes to the even output word just below it. The same word, rotated right by one byte and XORed with the constant in its low byte, goes to the odd output word. Bytes are numbered little-endian: byte n sits at bits 8n+7..8n, and 32-bit word k covers bytes 4k..4k+3. The S-box is computed as the GF(2^8) inverse, with reduction polynomial 0x11B, followed by the standard affine map with constant 0x63.

Top module: `aes_keyassist`

## Requirements
- R1: While reset (rstN low) is held, and at the first sample after it, outValid is 0 and outResult is all zero.
- R2: outValid is high in the cycle after each cycle in which inValid is high, and low otherwise. A new input is accepted on every cycle, including back-to-back cycles.
- R3: Source words 0 and 2 (bytes 0-3 and 8-11) have no effect on the result.
- R4: Output word 0 equals source word 1 with each of its four bytes replaced by its forward S-box value. For example, lane value 0xff530100 gives 0x16ed7c63.
- R5: Output word 2 equals source word 3 substituted bytewise in the same way. For example, 0x00000000 gives 0x63636363.
- R6: Output word 1 equals substituted word 1 rotated right by 8 bits, so that its byte 0 moves to byte 3, XORed with {24'b0, inRcon}. The constant touches only byte 0 of the word.
- R7: Output word 3 is built from substituted word 3 in the same way as R6, using the same constant.
- R8: In a cycle after which inValid was low, outResult keeps its previous value.
- R9: When the unit's word 3 is chained with XOR by the surrounding logic, it yields the full AES-128 round-key schedule for the constants 01,02,04,08,10,20,40,80,1B,36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Source and constant are valid this cycle |
| inSrc | input | 128 | Source block, byte 0 at bits 7:0 |
| inRcon | input | 8 | Round constant |
| outValid | output | 1 | Result is valid |
| outResult | output | 128 | Substituted and rotated words |

## Verification
Every result is due exactly one rising edge after the input that produced it. The bench drives inputs on falling edges. A behavioural model updates its expected value at the same rising edge as the design, and outputs are compared at each following falling edge, so every sample sees a settled result one edge after its stimulus. Directed checks read the result at the falling edge right after the accepting edge. These cover known S-box values, changes to the ignored words, idle holding and a ten-round key schedule. The schedule feeds each round's result back as the next source, one round per two cycles.

// File: rtl/aes_keyassist_pkg.sv
package aes_keyassist_pkg;

  typedef struct packed {
    logic capture;
  } kaStrobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
    end
    return acc;
  endfunction

  // inverse as x^254, then affine map
  function automatic logic [7:0] fwdSbox(input logic [7:0] x);
    logic [7:0] pw;
    logic [7:0] inv;
    pw  = x;
    inv = 8'h01;
    for (int i = 0; i < 7; i++) begin
      pw  = gfMul(pw, pw);
      inv = gfMul(inv, pw);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_keyassist_ctrl.sv
module aes_keyassist_ctrl
  import aes_keyassist_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output kaStrobe_t strobes,
  output logic      outValid
);
  always_comb strobes.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/aes_keyassist_dp.sv
module aes_keyassist_dp
  import aes_keyassist_pkg::*;
#(
  parameter int LANE_COUNT = 4,
  parameter int LANE_W     = 32,
  parameter int RCON_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  kaStrobe_t                    strobes,
  input  logic [LANE_COUNT*LANE_W-1:0] inSrc,
  input  logic [RCON_W-1:0]            inRcon,
  output logic [LANE_COUNT*LANE_W-1:0] outResult
);
  localparam int BLOCK_W   = LANE_COUNT * LANE_W;
  localparam int PAIRS     = LANE_COUNT / 2;
  localparam int BYTES_LN  = LANE_W / 8;

  logic [BLOCK_W-1:0] nextResult;

  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    logic [LANE_W-1:0] srcLane;
    logic [LANE_W-1:0] subLane;
    assign srcLane = inSrc[(2*p+1)*LANE_W +: LANE_W];
    for (genvar b = 0; b < BYTES_LN; b++) begin : gByte
      assign subLane[8*b +: 8] = fwdSbox(srcLane[8*b +: 8]);
    end
    assign nextResult[(2*p)*LANE_W +: LANE_W]   = subLane;
    assign nextResult[(2*p+1)*LANE_W +: LANE_W] =
      {subLane[7:0], subLane[LANE_W-1:8]} ^ {{(LANE_W-RCON_W){1'b0}}, inRcon};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outResult <= '0;
    else if (strobes.capture) outResult <= nextResult;
  end
endmodule

// File: rtl/aes_keyassist.sv
module aes_keyassist
  import aes_keyassist_pkg::*;
#(
  parameter int LANE_COUNT = 4,
  parameter int LANE_W     = 32,
  parameter int RCON_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [LANE_COUNT*LANE_W-1:0] inSrc,
  input  logic [RCON_W-1:0]            inRcon,
  output logic                         outValid,
  output logic [LANE_COUNT*LANE_W-1:0] outResult
);
  kaStrobe_t strobes;

  aes_keyassist_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  aes_keyassist_dp #(.LANE_COUNT(LANE_COUNT), .LANE_W(LANE_W), .RCON_W(RCON_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inSrc(inSrc), .inRcon(inRcon), .outResult(outResult)
  );
endmodule

// File: rtl/aes_keyassist_chk.sv
module aes_keyassist_chk (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [7:0]   inRcon,
  input logic         outValid,
  input logic [127:0] outResult
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outResult));

  assert_odd_lane1_rcon_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (({outResult[7:0], outResult[31:8]} ^ outResult[63:32])
                 == {24'h0, $past(inRcon)}));

  assert_odd_lane3_rcon_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (({outResult[71:64], outResult[95:72]} ^ outResult[127:96])
                 == {24'h0, $past(inRcon)}));
endmodule

bind aes_keyassist aes_keyassist_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inRcon(inRcon),
  .outValid(outValid), .outResult(outResult)
);

// File: tb/aes_keyassist_tb.sv
module aes_keyassist_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] inSrc = '0;
  logic [7:0]   inRcon = '0;
  logic         outValid;
  logic [127:0] outResult;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;

  logic [7:0] sbTab [256];
  logic         expValid = 1'b0;
  logic [127:0] expResult = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_keyassist dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSrc(inSrc), .inRcon(inRcon),
    .outValid(outValid), .outResult(outResult)
  );

  function automatic int slowMul(int a, int b);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if ((b >> i) & 1) r ^= a;
      a = a << 1;
      if (a & 256) a ^= 'h11b;
    end
    return r & 255;
  endfunction

  function automatic logic [127:0] refCalc(logic [127:0] s, logic [7:0] rc);
    logic [127:0] r;
    logic [31:0] w;
    r = '0;
    for (int k = 1; k < 4; k += 2) begin
      for (int b = 0; b < 4; b++) w[8*b +: 8] = sbTab[s[32*k + 8*b +: 8]];
      r[32*(k-1) +: 32] = w;
      r[32*k +: 32] = ((w >> 8) | (w << 24)) ^ {24'h0, rc};
    end
    return r;
  endfunction

  function automatic logic [127:0] toLanes(logic [127:0] be);
    logic [127:0] le;
    for (int i = 0; i < 16; i++) le[8*i +: 8] = be[127-8*i -: 8];
    return le;
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, updated at the same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid  <= 1'b0;
      expResult <= '0;
    end else begin
      expValid <= inValid;
      if (inValid) expResult <= refCalc(inSrc, inRcon);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      check(outValid == expValid, "R2 model valid", {127'b0, outValid}, {127'b0, expValid});
      check(outResult == expResult, "R8 model result", outResult, expResult);
    end
  end

  task automatic drive(bit v, logic [127:0] s, logic [7:0] rc);
    @(negedge clk);
    inValid = v; inSrc = s; inRcon = rc;
  endtask

  logic [127:0] roundBe [11];
  logic [7:0]   rconSeq [10];
  logic [127:0] firstRes;

  initial begin
    for (int x = 0; x < 256; x++) begin
      int inv = 0;
      int s;
      for (int c = 1; c < 256; c++) if (slowMul(x, c) == 1) inv = c;
      s = inv ^ 'h63;
      for (int r = 1; r < 5; r++) s ^= ((inv << r) | (inv >> (8 - r))) & 255;
      sbTab[x] = s[7:0];
    end
    roundBe[0]  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    roundBe[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
    roundBe[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
    roundBe[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
    roundBe[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
    roundBe[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
    roundBe[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
    roundBe[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
    roundBe[8]  = 128'head27321b58dbad2312bf5607f8d292f;
    roundBe[9]  = 128'hac7766f319fadc2128d12941575c006e;
    roundBe[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    rconSeq = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};

    // R1: reset state
    repeat (2) @(negedge clk);
    check(outValid == 1'b0 && outResult == '0, "R1 in reset", outResult, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outResult == '0, "R1 after reset", outResult, '0);
    cmpOn = 1'b1;

    // R4..R7: known S-box values
    drive(1'b1, {32'h00000000, 32'hdeadbeef, 32'hff530100, 32'h12345678}, 8'h1b);
    drive(1'b0, '0, '0);
    check(outResult[31:0] == 32'h16ed7c63, "R4 word0", outResult, {96'h0, 32'h16ed7c63});
    check(outResult[95:64] == 32'h63636363, "R5 word2", outResult, {32'h0, 32'h63636363, 64'h0});
    check(outResult[63:32] == 32'h6316ed67, "R6 word1", outResult, {64'h0, 32'h6316ed67, 32'h0});
    check(outResult[127:96] == 32'h63636378, "R7 word3", outResult, {32'h63636378, 96'h0});
    check(outValid == 1'b1, "R2 valid after one edge", {127'b0, outValid}, 128'h1);
    firstRes = outResult;

    // R8: idle cycles hold the result
    drive(1'b0, {128{1'b1}}, 8'hff);
    drive(1'b0, {128{1'b1}}, 8'hff);
    check(outResult == firstRes && !outValid, "R8 hold", outResult, firstRes);

    // R3: even words changed, same result
    drive(1'b1, {32'h00000000, 32'hcafef00d, 32'hff530100, 32'h87654321}, 8'h1b);
    drive(1'b0, '0, '0);
    check(outResult == firstRes, "R3 even words ignored", outResult, firstRes);

    // R2: back-to-back inputs, model compares every cycle
    for (int i = 0; i < 6; i++)
      drive(1'b1, {4{32'h01020304 * (i + 3)}} ^ {i[7:0], 120'h0}, 8'(i * 37));
    drive(1'b0, '0, '0);
    check(outValid == 1'b1, "R2 last of burst valid", {127'b0, outValid}, 128'h1);
    drive(1'b0, '0, '0);
    check(outValid == 1'b0, "R2 burst end", {127'b0, outValid}, 128'h0);

    // R9: key schedule with bench-side XOR chaining
    begin
      logic [127:0] key;
      key = toLanes(roundBe[0]);
      for (int r = 0; r < 10; r++) begin
        logic [31:0] t;
        logic [127:0] nk;
        drive(1'b1, key, rconSeq[r]);
        drive(1'b0, '0, '0);
        t = outResult[127:96];
        nk[31:0]   = key[31:0] ^ t;
        nk[63:32]  = key[63:32] ^ nk[31:0];
        nk[95:64]  = key[95:64] ^ nk[63:32];
        nk[127:96] = key[127:96] ^ nk[95:64];
        check(nk == toLanes(roundBe[r+1]), $sformatf("R9 round %0d", r + 1),
              nk, toLanes(roundBe[r+1]));
        key = nk;
      end
    end

    cmpOn = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule